// File: doc/BRIEF.md
# Nested Exception Fault Escalator

This block sits in a processor's trap path. Each hardware exception is compared against a record of the exception currently being delivered. The block then decides whether the new event is delivered as raised, is promoted to a double fault (vector 8) with a zero error code, or stops the processor with a sticky shutdown request. Software interrupt instructions bypass the classification. The single-byte debug breakpoint also bypasses it and is delivered as vector 1.

An event is presented for one cycle on `evt_valid_i`. One clock edge later the block presents the final vector, error code, software-interrupt flag and return pointer, qualified by a one-cycle `out_valid_o`. The trap sequencer pulses `deliver_done_i` once a handler has been entered, and this clears the record. A misaligned access by an operation that requires alignment is reported on `evt_misalign_i`. It becomes a general protection fault (vector 13) and is classified like any other hardware exception.

Top module: `fault_esc`

## Requirements
- R1: After reset, `out_valid_o` and `shutdown_o` are 0, and the record holds an idle value that is neither contributory, 14 nor 8. A contributory fault raised first after reset is therefore delivered unchanged.
- R2: An accepted event gives `out_valid_o`=1 with its results on the next clock edge. `out_valid_o` is 0 in any cycle that follows a cycle without `evt_valid_i`.
- R3: Vectors 0, 10, 11, 12 and 13 are contributory. A contributory fault raised while the record holds a contributory vector is delivered as vector 8 with error code 0.
- R4: When the record holds 14 (page fault), a new contributory fault or a new page fault is delivered as vector 8 with error code 0.
- R5: Any other combination delivers the raised vector and error code unchanged, for example a page fault after a contributory fault.
- R6: The record is overwritten with the delivered vector only when that vector is contributory, 14 or 8. Other vectors leave the record as it was.
- R7: A hardware exception raised while the record holds 8 produces no `out_valid_o` and sets `shutdown_o` on the next edge. `shutdown_o` stays at 1 until reset, and events are dropped while it is set.
- R8: An event with `evt_swint_i`=1 keeps its vector and error code, reports `out_swint_o`=1, never escalates or shuts down, and leaves the record unchanged.
- R9: `ret_ip_o` equals `cur_ip_i` plus the zero-extended `ip_add_i`, modulo 2^IP_W.
- R10: An event with `evt_brk_i`=1 takes priority over all other event inputs. It delivers vector 1 with error code 0 and `out_swint_o`=0, and reports `cur_ip_i` as `ret_ip_o`. It is not classified, does not shut down, and leaves the record unchanged.
- R11: An event with `evt_misalign_i`=1 (and no breakpoint) replaces the raised vector with 13 and the error code with 0, and is then classified like other hardware exceptions.
- R12: `deliver_done_i` returns the record to idle. When it coincides with an accepted event that updates the record, the event's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event strobe, one cycle |
| evt_vec_i | input | VEC_W | Raised vector |
| evt_err_i | input | ERR_W | Raised error code |
| evt_swint_i | input | 1 | Event comes from a software interrupt instruction |
| evt_brk_i | input | 1 | Single-byte debug breakpoint event |
| evt_misalign_i | input | 1 | Misaligned access by an alignment-requiring operation |
| cur_ip_i | input | IP_W | Current instruction pointer |
| ip_add_i | input | ADD_W | Addend giving the next instruction pointer |
| deliver_done_i | input | 1 | Handler entered; clears the record |
| out_valid_o | output | 1 | Result valid pulse |
| out_vec_o | output | VEC_W | Final vector |
| out_err_o | output | ERR_W | Final error code |
| out_swint_o | output | 1 | Result is a software interrupt |
| ret_ip_o | output | IP_W | Return pointer |
| shutdown_o | output | 1 | Sticky shutdown request |

## Verification
The bench builds the block with IP_W=16, ERR_W=16 and ADD_W=4, keeping VEC_W at 8. The 16-bit pointer lets a small pointer near 0xFFFF carry past the top, so the modulo behaviour of the return pointer can be checked directly. The idle record value stays at 0xFF and cannot collide with any vector the bench raises. The escalation chains, from contributory to double fault and on to shutdown, are reached in two or three events each.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;
  localparam int unsigned VEC_DBL  = 8;
  localparam int unsigned VEC_PAGE = 14;
  localparam int unsigned VEC_GP   = 13;
  localparam int unsigned VEC_DBG  = 1;

  function automatic logic is_contrib(input int unsigned v);
    return (v == 0) || (v >= 10 && v <= 13);
  endfunction

  function automatic logic is_recordable(input int unsigned v);
    return is_contrib(v) || v == VEC_PAGE || v == VEC_DBL;
  endfunction
endpackage

// File: rtl/fault_classify.sv
module fault_classify
  import fault_esc_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic [VEC_W-1:0] rec_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             zero_err_o,
  output logic             upd_o,
  output logic             halt_o
);
  logic first_c, second_c, esc;

  always_comb begin
    first_c    = is_contrib(int'(rec_i));
    second_c   = is_contrib(int'(vec_i));
    halt_o     = (int'(rec_i) == VEC_DBL);
    esc        = (first_c && second_c) ||
                 ((int'(rec_i) == VEC_PAGE) && (second_c || int'(vec_i) == VEC_PAGE));
    vec_o      = esc ? VEC_W'(VEC_DBL) : vec_i;
    zero_err_o = esc;
    upd_o      = !halt_o && is_recordable(int'(vec_o));
  end
endmodule

// File: rtl/fault_record.sv
module fault_record
  import fault_esc_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  localparam logic [VEC_W-1:0] IDLE_VEC = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             clr_i,
  output logic [VEC_W-1:0] rec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rec_o <= IDLE_VEC;
    else if (upd_i) rec_o <= vec_i;
    else if (clr_i) rec_o <= IDLE_VEC;
  end

  assert_rec_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_o == IDLE_VEC || is_recordable(int'(rec_o)));
  assert_clear_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !upd_i |=> rec_o == IDLE_VEC);
  assert_upd_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> rec_o == $past(vec_i));
endmodule

// File: rtl/fault_esc.sv
module fault_esc
  import fault_esc_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned ERR_W = 32,
  parameter int unsigned IP_W  = 32,
  parameter int unsigned ADD_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [VEC_W-1:0] evt_vec_i,
  input  logic [ERR_W-1:0] evt_err_i,
  input  logic             evt_swint_i,
  input  logic             evt_brk_i,
  input  logic             evt_misalign_i,
  input  logic [IP_W-1:0]  cur_ip_i,
  input  logic [ADD_W-1:0] ip_add_i,
  input  logic             deliver_done_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] out_vec_o,
  output logic [ERR_W-1:0] out_err_o,
  output logic             out_swint_o,
  output logic [IP_W-1:0]  ret_ip_o,
  output logic             shutdown_o
);
  localparam int unsigned PAD_W = IP_W - ADD_W;

  logic [VEC_W-1:0] rec, hw_vec, cls_vec;
  logic [ERR_W-1:0] hw_err;
  logic             cls_zero, cls_upd, cls_halt;
  logic             accept, hw_evt, do_halt, do_upd;
  logic [IP_W-1:0]  next_ip;

  // misaligned access is reported as general protection, error code 0
  assign hw_vec = evt_misalign_i ? VEC_W'(VEC_GP) : evt_vec_i;
  assign hw_err = evt_misalign_i ? '0 : evt_err_i;

  fault_classify #(.VEC_W(VEC_W)) u_cls (
    .rec_i      (rec),
    .vec_i      (hw_vec),
    .vec_o      (cls_vec),
    .zero_err_o (cls_zero),
    .upd_o      (cls_upd),
    .halt_o     (cls_halt)
  );

  assign accept  = evt_valid_i && !shutdown_o;
  assign hw_evt  = accept && !evt_brk_i && !evt_swint_i;
  assign do_halt = hw_evt && cls_halt;
  assign do_upd  = hw_evt && cls_upd;
  assign next_ip = cur_ip_i + {{PAD_W{1'b0}}, ip_add_i};

  fault_record #(.VEC_W(VEC_W)) u_rec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (do_upd),
    .vec_i  (cls_vec),
    .clr_i  (deliver_done_i),
    .rec_o  (rec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_vec_o   <= '0;
      out_err_o   <= '0;
      out_swint_o <= 1'b0;
      ret_ip_o    <= '0;
      shutdown_o  <= 1'b0;
    end else begin
      out_valid_o <= accept && !do_halt;
      if (do_halt) shutdown_o <= 1'b1;
      if (accept) begin
        if (evt_brk_i) begin
          out_vec_o   <= VEC_W'(VEC_DBG);
          out_err_o   <= '0;
          out_swint_o <= 1'b0;
          ret_ip_o    <= cur_ip_i;
        end else if (evt_swint_i) begin
          out_vec_o   <= evt_vec_i;
          out_err_o   <= evt_err_i;
          out_swint_o <= 1'b1;
          ret_ip_o    <= next_ip;
        end else begin
          out_vec_o   <= cls_vec;
          out_err_o   <= cls_zero ? '0 : hw_err;
          out_swint_o <= 1'b0;
          ret_ip_o    <= next_ip;
        end
      end
    end
  end

  assert_idle_no_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> !out_valid_o);
  assert_shutdown_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> shutdown_o);
  assert_silent_in_shutdown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> !out_valid_o);
  assert_brk_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && evt_brk_i && !shutdown_o |=>
      out_valid_o && out_vec_o == VEC_W'(VEC_DBG) && out_err_o == '0 && !out_swint_o
      && ret_ip_o == $past(cur_ip_i) && !shutdown_o);
  assert_swint_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && evt_swint_i && !evt_brk_i && !shutdown_o |=>
      out_valid_o && out_swint_o && out_vec_o == $past(evt_vec_i) && !shutdown_o);
endmodule

// File: tb/tb_fault_esc.sv
module tb_fault_esc;
  localparam int VW = 8, EW = 16, IW = 16, AW = 4;

  logic clk = 0, rst_n = 0;
  logic ev = 0, sw = 0, brk = 0, mis = 0, done = 0;
  logic [VW-1:0] vec = '0;
  logic [EW-1:0] err = '0;
  logic [IW-1:0] ip = '0;
  logic [AW-1:0] add = '0;
  logic ov, osw, sd;
  logic [VW-1:0] ovec;
  logic [EW-1:0] oerr;
  logic [IW-1:0] oip;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  fault_esc #(.VEC_W(VW), .ERR_W(EW), .IP_W(IW), .ADD_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(ev), .evt_vec_i(vec), .evt_err_i(err),
    .evt_swint_i(sw), .evt_brk_i(brk), .evt_misalign_i(mis), .cur_ip_i(ip),
    .ip_add_i(add), .deliver_done_i(done), .out_valid_o(ov), .out_vec_o(ovec),
    .out_err_o(oerr), .out_swint_o(osw), .ret_ip_o(oip), .shutdown_o(sd));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one event for one cycle; returns at the negedge after the capturing edge
  task automatic send(int v, int e, bit s, bit b, bit m, int p, int a, bit d = 0);
    vec = VW'(v); err = EW'(e); sw = s; brk = b; mis = m; ip = IW'(p); add = AW'(a);
    done = d; ev = 1;
    @(negedge clk);
    ev = 0; sw = 0; brk = 0; mis = 0; done = 0;
  endtask

  task automatic expect_out(string req, int v, int e, bit s, int p);
    check({req, " valid"}, 64'(ov), 64'd1);
    check({req, " vec"}, 64'(ovec), 64'(v));
    check({req, " err"}, 64'(oerr), 64'(e));
    check({req, " swint"}, 64'(osw), 64'(s));
    check({req, " ret"}, 64'(oip), 64'(p));
  endtask

  task automatic clear_rec();
    done = 1; @(negedge clk); done = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic t_reset_R1();
    do_reset();
    check("R1 valid", 64'(ov), 0);
    check("R1 shutdown", 64'(sd), 0);
    send(13, 5, 0, 0, 0, 'h40, 0);
    expect_out("R1 first contributory", 13, 5, 0, 'h40);
    @(negedge clk);
    check("R2 pulse ends", 64'(ov), 0);
  endtask

  task automatic t_contrib_R3();
    clear_rec();
    send(0, 7, 0, 0, 0, 'h10, 0);
    expect_out("R3 first", 0, 7, 0, 'h10);
    send(12, 3, 0, 0, 0, 'h10, 0);
    expect_out("R3 escalate", 8, 0, 0, 'h10);
  endtask

  task automatic t_page_R4();
    clear_rec();
    send(14, 2, 0, 0, 0, 'h20, 0);
    expect_out("R4 page first", 14, 2, 0, 'h20);
    send(14, 9, 0, 0, 0, 'h20, 0);
    expect_out("R4 page on page", 8, 0, 0, 'h20);
    clear_rec();
    send(14, 2, 0, 0, 0, 'h20, 0);
    send(11, 6, 0, 0, 0, 'h20, 0);
    expect_out("R4 contrib on page", 8, 0, 0, 'h20);
  endtask

  task automatic t_pass_R5();
    clear_rec();
    send(10, 1, 0, 0, 0, 'h30, 0);
    send(14, 4, 0, 0, 0, 'h30, 0);
    expect_out("R5 page after contrib", 14, 4, 0, 'h30);
  endtask

  task automatic t_record_R6();
    clear_rec();
    send(13, 0, 0, 0, 0, 'h50, 0);
    send(6, 1, 0, 0, 0, 'h50, 0);
    expect_out("R6 benign", 6, 1, 0, 'h50);
    send(3, 2, 0, 0, 0, 'h50, 0);
    send(11, 2, 0, 0, 0, 'h50, 0);
    expect_out("R6 record kept", 8, 0, 0, 'h50);
  endtask

  task automatic t_swint_R8();
    clear_rec();
    send(13, 0, 0, 0, 0, 'h60, 0);
    send(13, 'h77, 1, 0, 0, 'h60, 2);
    expect_out("R8 swint contrib", 13, 'h77, 1, 'h62);
    send(10, 0, 0, 0, 0, 'h60, 0);
    expect_out("R8 record untouched", 8, 0, 0, 'h60);
    send('h80, 0, 1, 0, 0, 'h60, 2);
    expect_out("R8 swint during double", 'h80, 0, 1, 'h62);
    check("R8 no shutdown", 64'(sd), 0);
  endtask

  task automatic t_brk_R10();
    // record is 8 here
    send(5, 'h55, 1, 1, 1, 'h1234, 3);
    expect_out("R10 breakpoint", 1, 0, 0, 'h1234);
    check("R10 no shutdown", 64'(sd), 0);
  endtask

  task automatic t_ret_R9();
    send('h21, 0, 1, 0, 0, 'h100, 2);
    expect_out("R9 plain add", 'h21, 0, 1, 'h102);
    send('h21, 0, 1, 0, 0, 'hFFFE, 5);
    expect_out("R9 wrap", 'h21, 0, 1, 'h0003);
  endtask

  task automatic t_misalign_R11();
    clear_rec();
    send(3, 'hAA, 0, 0, 1, 'h70, 0);
    expect_out("R11 to GP", 13, 0, 0, 'h70);
    send(3, 'hAA, 0, 0, 1, 'h70, 0);
    expect_out("R11 classified", 8, 0, 0, 'h70);
  endtask

  task automatic t_clear_R12();
    clear_rec();
    send(14, 1, 0, 0, 0, 'h80, 0);
    send(6, 1, 0, 0, 0, 'h80, 0, 1);
    send(13, 2, 0, 0, 0, 'h80, 0);
    expect_out("R12 cleared", 13, 2, 0, 'h80);
    clear_rec();
    send(13, 2, 0, 0, 0, 'h80, 0, 1);
    send(12, 2, 0, 0, 0, 'h80, 0);
    expect_out("R12 update wins", 8, 0, 0, 'h80);
  endtask

  task automatic t_shutdown_R7();
    // record is 8 here
    send(6, 1, 0, 0, 0, 'h90, 0);
    check("R7 no delivery", 64'(ov), 0);
    check("R7 shutdown set", 64'(sd), 1);
    send(12, 1, 0, 0, 0, 'h90, 0);
    check("R7 dropped", 64'(ov), 0);
    send(12, 1, 0, 1, 0, 'h90, 0);
    check("R7 breakpoint dropped", 64'(ov), 0);
    check("R7 sticky", 64'(sd), 1);
    do_reset();
    check("R7 reset clears", 64'(sd), 0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_R1();
    t_contrib_R3();
    t_page_R4();
    t_pass_R5();
    t_record_R6();
    t_swint_R8();
    t_brk_R10();
    t_ret_R9();
    t_misalign_R11();
    t_clear_R12();
    t_shutdown_R7();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule